// File: doc/BRIEF.md
# On-Chip Data Space Router

This block holds the small on-chip data space of an 8-bit microcontroller core. It takes one request per cycle. Each request is tagged with an access kind: a direct byte, an indirect byte, a working register or a single bit. The block decides whether the request lands in on-chip RAM or in the special register file, then performs the read or the write. Reads are combinational from registered storage. Writes, including a bit write that rewrites one bit of its target byte, complete on the next rising clock edge.

A parameter selects one of two variants. The basic variant has 128 bytes of RAM, and its upper address half holds only special registers. The extended variant has 256 bytes of RAM. In that variant the upper half is reached by indirect requests, while direct requests to the same addresses still reach the special registers. Working registers and bit addresses are not separate storage. They are alternative views onto the same bytes. A two-bit bank field in the status register sets which group of eight working registers is in use.

Top module: `idm_data_space`

## Requirements
- R1: A direct or indirect byte access to addresses 0x00–0x7F reads and writes RAM, and both access kinds see the same byte at the same address.
- R2: A direct access to 0x80–0xFF reaches the special register file. The implemented registers are 0x80, 0x90, 0xD0, 0xE0 and 0xF0, all clearing to 0x00. Any other address in that range reads 0x00, ignores writes and raises `err`.
- R3: In the basic variant (`EXTENDED`=0), an indirect access to 0x80–0xFF reads 0x00, ignores writes and raises `err`. An indirect access never selects a special register.
- R4: A register access (`req_kind`=2) with register number n in `req_addr[2:0]` reaches RAM byte bank*8+n and aliases that byte for direct access.
- R5: The bank number is bits [4:3] of the status register at 0xD0. It is driven on `bank_sel` and takes effect for register accesses in the cycle after it is written.
- R6: A bit access (`req_kind`=3) with bit address b below 0x80 reaches bit b&7 of RAM byte 0x20+(b>>3). A bit read returns the bit in `rd_data[0]`, with the other bits zero. A bit write takes its value from `wdata[0]`.
- R7: A bit access with b at 0x80 or above reaches bit b&7 of the special register at b&0xF8. If that register is not implemented, the access raises `err`.
- R8: A bit write changes only the addressed bit of its target byte, in one clock.
- R9: After reset, every implemented special register reads 0x00 and `bank_sel` is 0.
- R10: In the extended variant (`EXTENDED`=1), an indirect access to 0x80–0xFF reaches upper RAM. That storage is independent of the special register that a direct access to the same address reaches.
- R11: No state changes unless `req_valid` and `req_wr` are both high. When `req_valid` is low, `rd_data` and `err` are 0. Access kind encodings: 0 direct, 1 indirect, 2 register, 3 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 direct, 1 indirect, 2 register, 3 bit |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wr | input | 1 | Write when high, read when low |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rd_data | output | 8 | Read result (byte, or bit in position 0) |
| err | output | 1 | Request targets nothing implemented |
| bank_sel | output | 2 | Current working-register bank |

## Verification
The case that is hardest to reach is the bit write into a special register that changes the register bank. Showing it takes three steps. The bench first loads a known pattern into the status register by a direct write. It then sets a single status bit through a bit address in the upper range. Finally it confirms that `bank_sel` moved and that a later register access lands in the new bank, which proves the read-modify-write and the bank overlay together. The second hard case is the split between upper RAM and special registers in the extended variant. For that, both variants run from one stimulus stream, and the bench interleaves indirect and direct writes to the same upper address, then reads each back.

// File: rtl/idm_pkg.sv
package idm_pkg;

    localparam int BYTE_W    = 8;
    localparam int SFR_NUM   = 5;
    localparam int SFR_IDX_W = $clog2(SFR_NUM);
    localparam int BANK_LSB  = 3;

    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_REG      = 2'd2,
        ACC_BIT      = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_SFR  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [BYTE_W-1:0]    addr;
        logic [2:0]           bitpos;
        logic                 is_bit;
        logic [SFR_IDX_W-1:0] sfr_idx;
    } dec_t;

    typedef struct packed {
        logic                 hit;
        logic [SFR_IDX_W-1:0] idx;
    } sfr_hit_t;

    // Index of the status register that carries the bank field.
    localparam int SFR_STATUS_IDX = 2;

    function automatic logic [BYTE_W-1:0] sfr_addr(input int i);
        case (i)
            0:       sfr_addr = 8'h80;
            1:       sfr_addr = 8'h90;
            2:       sfr_addr = 8'hD0;
            3:       sfr_addr = 8'hE0;
            default: sfr_addr = 8'hF0;
        endcase
    endfunction

    function automatic sfr_hit_t sfr_lookup(input logic [BYTE_W-1:0] a);
        sfr_hit_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = 0; i < SFR_NUM; i++) begin
            if (a == sfr_addr(i)) begin
                r.hit = 1'b1;
                r.idx = SFR_IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] merge_bit(input logic [BYTE_W-1:0] cur,
                                                    input logic [2:0] pos,
                                                    input logic val);
        logic [BYTE_W-1:0] m;
        m = cur;
        m[pos] = val;
        return m;
    endfunction

endpackage

// File: rtl/idm_decoder.sv
module idm_decoder
    import idm_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic              valid,
    input  acc_kind_e         kind,
    input  logic [BYTE_W-1:0] addr,
    input  logic [1:0]        bank,
    output dec_t              dec
);

    sfr_hit_t direct_hit;
    sfr_hit_t bit_hit;
    logic     upper;

    always_comb begin
        upper      = addr[BYTE_W-1];
        direct_hit = sfr_lookup(addr);
        bit_hit    = sfr_lookup({addr[BYTE_W-1:3], 3'b000});

        dec         = '0;
        dec.tgt     = TGT_NONE;
        dec.bitpos  = addr[2:0];

        if (valid) begin
            unique case (kind)
                ACC_DIRECT: begin
                    dec.addr = addr;
                    if (!upper) begin
                        dec.tgt = TGT_RAM;
                    end else if (direct_hit.hit) begin
                        dec.tgt     = TGT_SFR;
                        dec.sfr_idx = direct_hit.idx;
                    end
                end
                ACC_INDIRECT: begin
                    dec.addr = addr;
                    if (!upper || EXTENDED) begin
                        dec.tgt = TGT_RAM;
                    end
                end
                ACC_REG: begin
                    dec.addr = {3'b000, bank, addr[2:0]};
                    dec.tgt  = TGT_RAM;
                end
                ACC_BIT: begin
                    dec.is_bit = 1'b1;
                    if (!upper) begin
                        dec.addr = {4'b0010, addr[6:3]};
                        dec.tgt  = TGT_RAM;
                    end else begin
                        dec.addr = {addr[BYTE_W-1:3], 3'b000};
                        if (bit_hit.hit) begin
                            dec.tgt     = TGT_SFR;
                            dec.sfr_idx = bit_hit.idx;
                        end
                    end
                end
                default: dec.tgt = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/idm_ram.sv
module idm_ram
    import idm_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    // Contents are not reset; only the write port is sequential.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R11
    ram_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/idm_sfr_file.sv
module idm_sfr_file
    import idm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SFR_IDX_W-1:0] idx,
    input  logic                 we,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic [1:0]           bank
);

    logic [BYTE_W-1:0] regs [SFR_NUM];

    for (genvar g = 0; g < SFR_NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && idx == SFR_IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < SFR_NUM; i++) begin
            if (idx == SFR_IDX_W'(i)) rdata = regs[i];
        end
    end

    assign bank = regs[SFR_STATUS_IDX][BANK_LSB+1:BANK_LSB];

    // R5
    bank_follows_status_chk: assert property (@(posedge clk) disable iff (rst)
        (we && idx == SFR_IDX_W'(SFR_STATUS_IDX))
        |=> (bank == $past(wdata[BANK_LSB+1:BANK_LSB])));

    // R9
    bank_reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank == 2'b00));

endmodule

// File: rtl/idm_data_space.sv
module idm_data_space
    import idm_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    localparam int RAM_DEPTH = EXTENDED ? 256 : 128,
    localparam int RAM_AW    = $clog2(RAM_DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [7:0]  req_addr,
    input  logic        req_wr,
    input  logic [7:0]  req_wdata,
    output logic [7:0]  rd_data,
    output logic        err,
    output logic [1:0]  bank_sel
);

    dec_t              dec;
    acc_kind_e         kind;
    logic [BYTE_W-1:0] ram_rdata;
    logic [BYTE_W-1:0] sfr_rdata;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] new_byte;
    logic              do_write;
    logic              ram_we;
    logic              sfr_we;

    assign kind = acc_kind_e'(req_kind);

    idm_decoder #(.EXTENDED(EXTENDED)) u_dec (
        .valid (req_valid),
        .kind  (kind),
        .addr  (req_addr),
        .bank  (bank_sel),
        .dec   (dec)
    );

    idm_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .addr  (dec.addr[RAM_AW-1:0]),
        .we    (ram_we),
        .wdata (new_byte),
        .rdata (ram_rdata)
    );

    idm_sfr_file u_sfr (
        .clk   (clk),
        .rst   (rst),
        .idx   (dec.sfr_idx),
        .we    (sfr_we),
        .wdata (new_byte),
        .rdata (sfr_rdata),
        .bank  (bank_sel)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_RAM: cur_byte = ram_rdata;
            TGT_SFR: cur_byte = sfr_rdata;
            default: cur_byte = '0;
        endcase
        new_byte = dec.is_bit ? merge_bit(cur_byte, dec.bitpos, req_wdata[0])
                              : req_wdata;
        do_write = req_valid && req_wr && !rst;
        ram_we   = do_write && dec.tgt == TGT_RAM;
        sfr_we   = do_write && dec.tgt == TGT_SFR;
        err      = req_valid && dec.tgt == TGT_NONE;
        if (!req_valid) begin
            rd_data = '0;
        end else if (dec.is_bit) begin
            rd_data = {7'b0, cur_byte[dec.bitpos]};
        end else begin
            rd_data = cur_byte;
        end
    end

    // R3
    indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == ACC_INDIRECT) |-> (dec.tgt != TGT_SFR));

    // R4
    reg_in_bank_area_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == ACC_REG) |-> (dec.tgt == TGT_RAM && dec.addr < 8'h20));

    // R6
    low_bit_in_bit_area_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == ACC_BIT && !req_addr[7])
        |-> (dec.addr >= 8'h20 && dec.addr <= 8'h2F));

    // R2
    err_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!ram_we && !sfr_we && rd_data == 8'h00));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (rd_data == 8'h00 && !err && !ram_we && !sfr_we));

endmodule

// File: tb/sim_idm_data_space.sv
module sim_idm_data_space;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_addr = 8'h00;
    logic       req_wr = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic [7:0] rd0, rd1;
    logic       err0, err1;
    logic [1:0] bank0, bank1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    localparam logic [1:0] K_DIR = 2'd0, K_IND = 2'd1, K_REG = 2'd2, K_BIT = 2'd3;

    always #4 clk = ~clk;

    idm_data_space #(.EXTENDED(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
        .rd_data(rd0), .err(err0), .bank_sel(bank0));

    idm_data_space #(.EXTENDED(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
        .rd_data(rd1), .err(err1), .bank_sel(bank1));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wr = 1'b1; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] k, input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check("R9 bank u0", bank0, 0);
        check("R9 bank u1", bank1, 0);
        foreach (u0.u_sfr.regs[i]) begin end
        peek(K_DIR, 8'hD0); check("R9 status", rd0, 0);
        peek(K_DIR, 8'hE0); check("R9 accum", rd0, 0);
        peek(K_DIR, 8'hF0); check("R9 aux", rd1, 0);
    endtask

    task automatic t_low_ram;
        put(K_DIR, 8'h45, 8'h35);
        peek(K_DIR, 8'h45); check("R1 direct u0", rd0, 8'h35); check("R1 direct u1", rd1, 8'h35);
        peek(K_IND, 8'h45); check("R1 indirect alias", rd0, 8'h35);
        put(K_IND, 8'h10, 8'h77);
        peek(K_DIR, 8'h10); check("R1 indirect write", rd0, 8'h77);
    endtask

    task automatic t_sfr;
        put(K_DIR, 8'hE0, 8'hA5);
        peek(K_DIR, 8'hE0); check("R2 sfr rw", rd0, 8'hA5); check("R2 err clear", err0, 0);
        put(K_DIR, 8'h81, 8'h55);
        peek(K_DIR, 8'h81); check("R2 unimpl read", rd0, 0); check("R2 unimpl err", err0, 1);
        peek(K_DIR, 8'h80); check("R2 neighbour untouched", rd0, 0);
    endtask

    task automatic t_indirect_upper;
        put(K_IND, 8'h90, 8'h3C);
        peek(K_IND, 8'h90);
        check("R3 basic read zero", rd0, 0); check("R3 basic err", err0, 1);
        check("R10 ext upper ram", rd1, 8'h3C); check("R10 ext no err", err1, 0);
        peek(K_DIR, 8'h90); check("R3 sfr untouched", rd0, 0); check("R10 sfr untouched", rd1, 0);
        put(K_DIR, 8'h90, 8'h11);
        peek(K_IND, 8'h90); check("R10 upper ram kept", rd1, 8'h3C);
        peek(K_DIR, 8'h90); check("R10 sfr written", rd1, 8'h11);
    endtask

    task automatic t_banks;
        put(K_DIR, 8'h05, 8'h12);
        put(K_DIR, 8'hD0, 8'h10);
        #1; check("R5 bank 2", bank0, 2);
        put(K_REG, 8'h05, 8'h99);
        peek(K_DIR, 8'h15); check("R4 bank2 alias", rd0, 8'h99);
        peek(K_DIR, 8'h05); check("R4 bank0 untouched", rd0, 8'h12);
        put(K_DIR, 8'hD0, 8'h18);
        put(K_DIR, 8'h1F, 8'h6E);
        peek(K_REG, 8'h07); check("R4 bank3 r7", rd0, 8'h6E);
        put(K_DIR, 8'hD0, 8'h00);
        peek(K_REG, 8'h05); check("R5 back to bank0", rd0, 8'h12);
    endtask

    task automatic t_bits_low;
        put(K_DIR, 8'h2A, 8'h00);
        put(K_BIT, 8'h55, 8'h01);
        peek(K_DIR, 8'h2A); check("R6 bit set byte", rd0, 8'h20);
        peek(K_BIT, 8'h55); check("R6 bit read one", rd0, 1);
        peek(K_BIT, 8'h54); check("R6 bit read zero", rd0, 0);
        put(K_DIR, 8'h2A, 8'hFF);
        put(K_BIT, 8'h50, 8'h00);
        peek(K_DIR, 8'h2A); check("R8 clear one bit", rd0, 8'hFE);
    endtask

    task automatic t_bits_high;
        put(K_BIT, 8'hE3, 8'h01);
        peek(K_DIR, 8'hE0); check("R7 sfr bit set", rd0, 8'hAD);
        put(K_DIR, 8'hD0, 8'h01);
        put(K_BIT, 8'hD4, 8'h01);
        #1; check("R8 status bit bank", bank0, 2);
        peek(K_DIR, 8'hD0); check("R8 status rmw", rd0, 8'h11);
        put(K_REG, 8'h01, 8'h5A);
        peek(K_DIR, 8'h11); check("R5 bank via bit", rd0, 8'h5A);
        peek(K_BIT, 8'h89); check("R7 unimpl bit err", err0, 1); check("R7 unimpl bit zero", rd0, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b1; req_kind = K_DIR; req_addr = 8'h45; req_wdata = 8'hC3;
        #1; check("R11 idle rd", rd0, 0); check("R11 idle err", err1, 0);
        @(negedge clk);
        req_valid = 1'b1; req_wr = 1'b0; req_wdata = 8'hC3;
        @(negedge clk); #1;
        check("R11 read no write", rd0, 8'h35);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_low_ram;
        t_sfr;
        t_indirect_upper;
        t_banks;
        t_bits_low;
        t_bits_high;
        t_idle;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule